// File: doc/BRIEF.md
# Two-Word Digital Alarm Checker

This block performs alarm checking in hardware over two 16-bit words. The first word is the supply status. The block samples it each cycle, compares it against a nominal pattern the host programs, and masks the difference. The result is a bad-bits word, in which a 1 marks a status bit that is out of tolerance. The second word is an interrupt-source register. Its expected value is zero and cannot be changed. Bit 0 of this register carries the masked status-error result. Other bits latch illegal host writes and attempts to modify the active ramp. Two more bits report a missing machine-data pulse or a missing timing-clock pulse within a one-second window.

An interrupt request is raised whenever a bit of the source register is set and that bit is enabled in the source mask. The host reaches the block through a small command port carrying a function code, a subaddress and 16 bits of write data. Through this port it reads and writes the nominal and both masks, reads the raw status, the bad-bits word and the source register, and turns the request output on or off. Turning the request off is how the alarm is bypassed.

Top module: `alm_two_word`

## Requirements
- R1: The bad-bits word equals (sampled status XOR nominal) AND status mask. It is read with function 0, subaddress 5.
- R2: Function 0, subaddress 0 returns the status word as sampled on the previous clock edge.
- R3: The status nominal is written with function 16, subaddress 2, and read back with function 0, subaddress 2. It holds its value unless it is written.
- R4: The status mask is written with function 16, subaddress 3, and read back with function 0, subaddress 3.
- R5: The source mask is written with function 16, subaddress 4, and read back with function 0, subaddress 4. Its reset value is 0x0001.
- R6: Function 0, subaddress 6 returns the source register. Bit 0 of that register is 1 exactly when the bad-bits word of the previous cycle was nonzero.
- R7: Bit 15 is set by an illegal-write pulse and bit 14 by an active-ramp-modify pulse. Each stays set until a source-register read. That read returns the value before clearing. A pulse that arrives in the same cycle as the read leaves the bit set.
- R8: On each window tick, bit 13 (machine-data) and bit 12 (timing clock) each become 1 if no pulse of their signal arrived since the previous tick, counting the tick cycle itself, and 0 otherwise. Between ticks they hold.
- R9: The interrupt request is registered. It is 1 one cycle after a cycle in which the enable was 1 and (source register AND source mask) was nonzero, and 0 otherwise.
- R10: Function 26 (any subaddress) enables the request and function 24 disables it. Reset leaves it disabled, and while it is disabled the request output stays 0.
- R11: After reset, the nominal, the status mask, the source register, the read data and the request are all 0.
- R12: Writes to subaddresses 5 and 6, and any function code other than 0, 16, 24 and 26, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_in | input | 16 | Supply status word |
| ill_write_evt | input | 1 | Illegal host-write pulse |
| ramp_mod_evt | input | 1 | Active-ramp modify attempt pulse |
| mdat_pulse | input | 1 | Machine-data activity pulse |
| tclk_pulse | input | 1 | Timing-clock activity pulse |
| window_tick | input | 1 | One-second window boundary pulse |
| host_stb | input | 1 | Command strobe, one cycle per command |
| host_func | input | 5 | Function code |
| host_sub | input | 4 | Subaddress |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, registered |
| irq | output | 1 | Interrupt request |

## Verification
Read data is due one edge after the strobe and is sampled at the next falling edge. A status change reaches the bad-bits word one edge later, source bit 0 two edges later and the request three edges later. For this reason the directed reads wait two idle cycles after any status or event change. Sticky and window bits change on the edge that samples the pulse or tick. A reference model, written as plain per-edge updates, is compared with the request and the read data at every falling edge. Directed checks then pin the corner cases to hand-computed constants: a read racing an event, a pulse in the tick cycle, and ignored writes.

// File: rtl/alm_pkg.sv
package alm_pkg;
   localparam int FUNC_W = 5;
   localparam int SUB_W  = 4;

   localparam logic [FUNC_W-1:0] F_READ    = 5'd0;
   localparam logic [FUNC_W-1:0] F_WRITE   = 5'd16;
   localparam logic [FUNC_W-1:0] F_IRQ_OFF = 5'd24;
   localparam logic [FUNC_W-1:0] F_IRQ_ON  = 5'd26;

   localparam logic [SUB_W-1:0] A_STAT = 4'd0;
   localparam logic [SUB_W-1:0] A_NOM  = 4'd2;
   localparam logic [SUB_W-1:0] A_SMSK = 4'd3;
   localparam logic [SUB_W-1:0] A_LMSK = 4'd4;
   localparam logic [SUB_W-1:0] A_BAD  = 4'd5;
   localparam logic [SUB_W-1:0] A_SRC  = 4'd6;

   localparam int B_SERR = 0;
   localparam int B_TCLK = 12;
   localparam int B_MDAT = 13;
   localparam int B_RAMP = 14;
   localparam int B_ILL  = 15;

   localparam int N_MON = 2;

   typedef struct packed {
      logic             rd;
      logic             wr;
      logic             on;
      logic             off;
      logic [SUB_W-1:0] sub;
   } host_cmd_t;

   function automatic host_cmd_t decode_cmd(input logic stb,
                                            input logic [FUNC_W-1:0] f,
                                            input logic [SUB_W-1:0] a);
      host_cmd_t c;
      c.rd  = stb && (f == F_READ);
      c.wr  = stb && (f == F_WRITE);
      c.on  = stb && (f == F_IRQ_ON);
      c.off = stb && (f == F_IRQ_OFF);
      c.sub = a;
      return c;
   endfunction

   function automatic int mon_bit(input int idx);
      return (idx == 0) ? B_MDAT : B_TCLK;
   endfunction
endpackage

// File: rtl/alm_status_cmp.sv
module alm_status_cmp
   import alm_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] status_in,
   input  logic [DW-1:0] nom,
   input  logic [DW-1:0] smask,
   output logic [DW-1:0] status_q,
   output logic [DW-1:0] bad,
   output logic          bad_any
);
   always_ff @(posedge clk) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= status_in;
   end

   always_comb begin
      bad     = (status_q ^ nom) & smask;
      bad_any = |bad;
   end

   assert_bad_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (smask == '0) |-> !bad_any);
endmodule

// File: rtl/alm_host_regs.sv
module alm_host_regs
   import alm_pkg::*;
#(
   parameter int              DW        = 16,
   parameter logic [DW-1:0]   LMASK_RST = 16'h0001
) (
   input  logic          clk,
   input  logic          rst_n,
   input  host_cmd_t     cmd,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] nom,
   output logic [DW-1:0] smask,
   output logic [DW-1:0] lmask,
   output logic          irq_en
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nom    <= '0;
         smask  <= '0;
         lmask  <= LMASK_RST;
         irq_en <= 1'b0;
      end else begin
         if (cmd.wr) begin
            case (cmd.sub)
               A_NOM:   nom   <= wdata;
               A_SMSK:  smask <= wdata;
               A_LMSK:  lmask <= wdata;
               default: ;
            endcase
         end
         if (cmd.on)       irq_en <= 1'b1;
         else if (cmd.off) irq_en <= 1'b0;
      end
   end

   assert_nom_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd.wr && cmd.sub == A_NOM) |=> $stable(nom));
   assert_en_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.on |=> irq_en);
   assert_en_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.off |=> !irq_en);
endmodule

// File: rtl/alm_src_reg.sv
module alm_src_reg
   import alm_pkg::*;
#(
   parameter int DW   = 16,
   parameter int NMON = N_MON
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bad_any,
   input  logic            ill_evt,
   input  logic            ramp_evt,
   input  logic [NMON-1:0] mon_pulse,
   input  logic            tick,
   input  logic            rd_clr,
   output logic [DW-1:0]   src
);
   logic            serr_q, ill_q, ramp_q;
   logic [NMON-1:0] miss_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         serr_q <= 1'b0;
         ill_q  <= 1'b0;
         ramp_q <= 1'b0;
      end else begin
         serr_q <= bad_any;
         ill_q  <= (ill_q  && !rd_clr) || ill_evt;
         ramp_q <= (ramp_q && !rd_clr) || ramp_evt;
      end
   end

   for (genvar i = 0; i < NMON; i++) begin : g_mon
      logic seen_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            seen_q    <= 1'b0;
            miss_q[i] <= 1'b0;
         end else if (tick) begin
            seen_q    <= 1'b0;
            miss_q[i] <= !(seen_q || mon_pulse[i]);
         end else begin
            seen_q    <= seen_q || mon_pulse[i];
         end
      end
   end

   always_comb begin
      src         = '0;
      src[B_SERR] = serr_q;
      src[B_ILL]  = ill_q;
      src[B_RAMP] = ramp_q;
      for (int i = 0; i < NMON; i++) src[mon_bit(i)] = miss_q[i];
   end

   assert_serr_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bad_any |=> src[B_SERR]);
   assert_ill_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (src[B_ILL] && !rd_clr) |=> src[B_ILL]);
   assert_ramp_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_evt |=> src[B_RAMP]);
   assert_miss_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(src[B_MDAT:B_TCLK]));
endmodule

// File: rtl/alm_two_word.sv
module alm_two_word
   import alm_pkg::*;
#(
   parameter int            DW        = 16,
   parameter logic [DW-1:0] LMASK_RST = 16'h0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DW-1:0]     status_in,
   input  logic              ill_write_evt,
   input  logic              ramp_mod_evt,
   input  logic              mdat_pulse,
   input  logic              tclk_pulse,
   input  logic              window_tick,
   input  logic              host_stb,
   input  logic [FUNC_W-1:0] host_func,
   input  logic [SUB_W-1:0]  host_sub,
   input  logic [DW-1:0]     host_wdata,
   output logic [DW-1:0]     host_rdata,
   output logic              irq
);
   if (DW < 16) begin : g_bad_width
      $error("alm_two_word: DW must be at least 16 to hold the source bits");
   end

   host_cmd_t     cmd;
   logic [DW-1:0] nom, smask, lmask, status_q, bad, src;
   logic          irq_en, bad_any;

   assign cmd = decode_cmd(host_stb, host_func, host_sub);

   alm_host_regs #(.DW(DW), .LMASK_RST(LMASK_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .wdata(host_wdata),
      .nom(nom), .smask(smask), .lmask(lmask), .irq_en(irq_en)
   );

   alm_status_cmp #(.DW(DW)) u_cmp (
      .clk(clk), .rst_n(rst_n), .status_in(status_in), .nom(nom),
      .smask(smask), .status_q(status_q), .bad(bad), .bad_any(bad_any)
   );

   alm_src_reg #(.DW(DW), .NMON(N_MON)) u_src (
      .clk(clk), .rst_n(rst_n), .bad_any(bad_any),
      .ill_evt(ill_write_evt), .ramp_evt(ramp_mod_evt),
      .mon_pulse({tclk_pulse, mdat_pulse}), .tick(window_tick),
      .rd_clr(cmd.rd && cmd.sub == A_SRC), .src(src)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq        <= 1'b0;
         host_rdata <= '0;
      end else begin
         irq <= irq_en && (|(src & lmask));
         if (cmd.rd) begin
            case (cmd.sub)
               A_STAT:  host_rdata <= status_q;
               A_NOM:   host_rdata <= nom;
               A_SMSK:  host_rdata <= smask;
               A_LMSK:  host_rdata <= lmask;
               A_BAD:   host_rdata <= bad;
               A_SRC:   host_rdata <= src;
               default: host_rdata <= '0;
            endcase
         end
      end
   end

   assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |=> !irq);
   assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(|(src & lmask)));
endmodule

// File: tb/tb_alm_two_word.sv
module tb_alm_two_word;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] status_in = '0;
   logic        ill_write_evt = 0, ramp_mod_evt = 0, mdat_pulse = 0;
   logic        tclk_pulse = 0, window_tick = 0, host_stb = 0;
   logic [4:0]  host_func = '0;
   logic [3:0]  host_sub = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        irq;

   int checks = 0, fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   alm_two_word dut (
      .clk(clk), .rst_n(rst_n), .status_in(status_in),
      .ill_write_evt(ill_write_evt), .ramp_mod_evt(ramp_mod_evt),
      .mdat_pulse(mdat_pulse), .tclk_pulse(tclk_pulse),
      .window_tick(window_tick), .host_stb(host_stb), .host_func(host_func),
      .host_sub(host_sub), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .irq(irq)
   );

   // reference model, updated on each rising edge
   logic [15:0] m_stat, m_nom, m_smask, m_lmask, m_src, m_rdata;
   logic        m_en, m_irq, m_seen_md, m_seen_tc;
   string       m_tag = "R11";

   always @(posedge clk) begin
      logic [15:0] bad, nsrc;
      logic        clr;
      if (!rst_n) begin
         m_stat <= 0; m_nom <= 0; m_smask <= 0; m_lmask <= 16'h0001;
         m_src <= 0; m_rdata <= 0; m_en <= 0; m_irq <= 0;
         m_seen_md <= 0; m_seen_tc <= 0;
      end else begin
         bad = (m_stat ^ m_nom) & m_smask;
         clr = host_stb && host_func == 0 && host_sub == 6;
         nsrc = 0;
         nsrc[0]  = |bad;
         nsrc[15] = (m_src[15] && !clr) || ill_write_evt;
         nsrc[14] = (m_src[14] && !clr) || ramp_mod_evt;
         if (window_tick) begin
            nsrc[13] = !(m_seen_md || mdat_pulse);
            nsrc[12] = !(m_seen_tc || tclk_pulse);
            m_seen_md <= 0;
            m_seen_tc <= 0;
         end else begin
            nsrc[13] = m_src[13];
            nsrc[12] = m_src[12];
            m_seen_md <= m_seen_md || mdat_pulse;
            m_seen_tc <= m_seen_tc || tclk_pulse;
         end
         m_irq  <= m_en && (|(m_src & m_lmask));
         m_stat <= status_in;
         m_src  <= nsrc;
         if (host_stb && host_func == 16) begin
            if (host_sub == 2) m_nom   <= host_wdata;
            if (host_sub == 3) m_smask <= host_wdata;
            if (host_sub == 4) m_lmask <= host_wdata;
         end
         if (host_stb && host_func == 26) m_en <= 1;
         if (host_stb && host_func == 24) m_en <= 0;
         if (host_stb && host_func == 0) begin
            case (host_sub)
               0: begin m_rdata <= m_stat;  m_tag = "R2"; end
               2: begin m_rdata <= m_nom;   m_tag = "R3"; end
               3: begin m_rdata <= m_smask; m_tag = "R4"; end
               4: begin m_rdata <= m_lmask; m_tag = "R5"; end
               5: begin m_rdata <= bad;     m_tag = "R1"; end
               6: begin m_rdata <= m_src;   m_tag = "R6"; end
               default: begin m_rdata <= 0; m_tag = "R12"; end
            endcase
         end
      end
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one clock; compare with the model at the falling edge
   task automatic cyc();
      @(negedge clk);
      if (rst_n) begin
         chk(m_tag, host_rdata, m_rdata);
         chk(m_en ? "R9" : "R10", {15'd0, irq}, {15'd0, m_irq});
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic cmd(input logic [4:0] f, input logic [3:0] a, input logic [15:0] d);
      host_stb = 1; host_func = f; host_sub = a; host_wdata = d;
      cyc();
      host_stb = 0; host_func = 0; host_sub = 0; host_wdata = 0;
   endtask

   task automatic rd(input logic [3:0] a, input string req, input logic [15:0] exp);
      cmd(5'd0, a, 16'h0);
      chk(req, host_rdata, exp);
   endtask

   task automatic pulse(ref logic s);
      s = 1; cyc(); s = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      chk("R11", host_rdata, 16'h0000);
      chk("R11", {15'd0, irq}, 16'h0000);
      rd(4, "R5", 16'h0001);
      rd(2, "R11", 16'h0000);
      rd(6, "R11", 16'h0000);

      cmd(16, 2, 16'h00F0);
      rd(2, "R3", 16'h00F0);
      cmd(16, 3, 16'h00FF);
      rd(3, "R4", 16'h00FF);

      status_in = 16'h00F0; idle(2);
      rd(5, "R1", 16'h0000);
      rd(6, "R6", 16'h0000);
      status_in = 16'h0F0F; idle(2);
      rd(5, "R1", 16'h00FF);
      rd(0, "R2", 16'h0F0F);
      rd(6, "R6", 16'h0001);

      idle(1);
      chk("R10", {15'd0, irq}, 16'h0000);
      cmd(26, 0, 0); idle(2);
      chk("R9", {15'd0, irq}, 16'h0001);
      cmd(24, 0, 0); idle(2);
      chk("R10", {15'd0, irq}, 16'h0000);

      pulse(ill_write_evt); idle(1);
      rd(6, "R7", 16'h8001);
      rd(6, "R7", 16'h0001);

      cmd(16, 4, 16'h8000);
      rd(4, "R5", 16'h8000);
      cmd(26, 0, 0); idle(2);
      chk("R9", {15'd0, irq}, 16'h0000);
      pulse(ill_write_evt); idle(2);
      chk("R9", {15'd0, irq}, 16'h0001);
      rd(6, "R7", 16'h8001); idle(2);
      chk("R9", {15'd0, irq}, 16'h0000);

      ramp_mod_evt = 1;
      rd(6, "R7", 16'h0001);
      ramp_mod_evt = 0;
      rd(6, "R7", 16'h4001);
      rd(6, "R7", 16'h0001);

      pulse(window_tick); idle(1);
      rd(6, "R8", 16'h3001);
      pulse(mdat_pulse); idle(1);
      rd(6, "R8", 16'h3001);
      pulse(window_tick); idle(1);
      rd(6, "R8", 16'h1001);
      tclk_pulse = 1; window_tick = 1; cyc();
      tclk_pulse = 0; window_tick = 0; idle(1);
      rd(6, "R8", 16'h2001);

      cmd(16, 5, 16'hFFFF);
      cmd(16, 6, 16'hFFFF);
      cmd(17, 2, 16'h1234);
      cmd(18, 4, 16'h1234); idle(2);
      rd(2, "R12", 16'h00F0);
      rd(4, "R12", 16'h8000);
      rd(5, "R12", 16'h00FF);
      rd(6, "R12", 16'h2001);
      chk("R12", {15'd0, irq}, 16'h0000);

      idle(3);
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule